// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block runs one indivisible operand access on an asynchronous 32-bit bus. The access always begins with a read portion and may end with a write portion. During the read portion it drives address, function code, size and a read/write level, raises the address and data strobes, and enables the external data buffers. It then waits for one of two acknowledge inputs, samples a cache-inhibit input and captures the operand from the correct byte lanes. If the operation is not flagged read-only, a fixed number of idle clocks follows, and then a write portion puts the modified operand back at the same address. Address and function code stay unchanged across the whole operation.

Each clock of `clk` stands for one half-clock bus state. The bus states are labelled S0 to S5 for the read portion, gap states for the idle clocks, and S6 to S11 for the write portion. One wait clock is added after S2 (read) or S9 (write) for each sample in which no acknowledge bit is set. A request is accepted only when the sequencer is idle. A one-clock `done` pulse marks the end of the operation.

Top module: `rmw_bus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_as`, `bus_ds`, `bus_dben`, `bus_d_oe` and `done` are 0 and `bus_rw` is 1.
- R2: A read portion holds `bus_as` high for exactly 4+w consecutive cycles, where w is the number of read wait clocks. `bus_ds` is never high while `bus_as` is low.
- R3: An acknowledge is recognised when either bit of `ack` is 1 at the clock edge that ends S2 (read) or S9 (write). Otherwise one wait clock is inserted per edge until an acknowledge bit is seen.
- R4: The operand length in bytes comes from `size_in`: 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4. For a byte offset a = `addr_in[1:0]`, the operand's lowest byte sits on bus bits [8(4-a-n)+7 : 8(4-a-n)], and higher bytes are on the lanes above it. `rd_data` returns the operand right-justified, with unused upper bits set to 0.
- R5: When `rd_only` is 1, no write portion follows. `bus_rw` stays 1 and `done` pulses in the cycle after the first cycle in which `bus_as` is low again.
- R6: When `rd_only` is 0, `bus_rw` goes low exactly IDLE_CLKS+1 cycles after `bus_as` falls at the end of the read. `bus_d_oe` rises exactly 2 cycles after `bus_rw` falls. The write `bus_as` pulse lasts 4+w cycles, where w is the write wait clocks.
- R7: While `bus_d_oe` is 1, `bus_d_out` carries the low n bytes of `wr_data` on the same lanes as R4, with all other lanes 0.
- R8: `bus_addr` stays at the accepted address for every cycle in which `bus_as` is high during that operation.
- R9: A `start` pulse while an operation is in progress is ignored.
- R10: `done` is high for exactly one cycle. `rd_data` and `rd_uncached` keep their values after `done` until a later read captures new ones.
- R11: `bus_d_oe` is never 1 while `bus_rw` is 1.
- R12: `rd_uncached` returns the level of `cinh` sampled as S4 begins, and it is published together with `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (accepted only when idle) |
| addr_in | input | 32 | Operand address |
| fc_in | input | 3 | Function code for the operation |
| size_in | input | 2 | Operand size code |
| wr_data | input | 32 | Right-justified value for the write portion |
| rd_only | input | 1 | 1: skip the write portion |
| ack | input | 2 | Acknowledge inputs from the slave, active high |
| cinh | input | 1 | Cache-inhibit input from the slave |
| bus_d_in | input | 32 | Data bus as seen from the slave |
| bus_addr | output | 32 | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_siz | output | 2 | Bus size code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_dben | output | 1 | Data buffer enable, active high |
| bus_d_out | output | 32 | Data driven during the write portion |
| bus_d_oe | output | 1 | Output enable for `bus_d_out` |
| rd_data | output | 32 | Captured operand, right-justified |
| rd_uncached | output | 1 | Cache-inhibit level sampled with the read |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The most delicate case is the cycle where the read strobes are released. In that same cycle the slave's acknowledge is still high, and a write portion is about to start. If wait-state sampling leaked into the next portion, or if the data drivers were turned on early, they would overlap with the departing read data. The bench provokes this with a slave that keeps its acknowledge up until it sees the data strobe fall, using delays of one to five samples on either acknowledge bit. It then judges the overlap by timing the fall of R/W and the rise of the output enable against the fall of the read strobe, and by counting the exact strobe widths of both portions.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_RWAIT, ST_S3, ST_S4, ST_S5,
    ST_GAP, ST_S6, ST_S7, ST_S8, ST_S9, ST_WWAIT, ST_S10, ST_S11
  } bus_state_e;

  typedef struct packed {
    logic as;
    logic ds;
    logic dben;
    logic rw;
    logic oe;
  } strobe_t;

  // Control levels that belong to each bus state
  function automatic strobe_t strobe_of(bus_state_e s);
    strobe_t o;
    o = '{as: 1'b0, ds: 1'b0, dben: 1'b0, rw: 1'b1, oe: 1'b0};
    unique case (s)
      ST_S1:                      o = '{as: 1'b1, ds: 1'b1, dben: 1'b0, rw: 1'b1, oe: 1'b0};
      ST_S2, ST_RWAIT,
      ST_S3, ST_S4:               o = '{as: 1'b1, ds: 1'b1, dben: 1'b1, rw: 1'b1, oe: 1'b0};
      ST_S6:                      o = '{as: 1'b0, ds: 1'b0, dben: 1'b0, rw: 1'b0, oe: 1'b0};
      ST_S7:                      o = '{as: 1'b1, ds: 1'b0, dben: 1'b0, rw: 1'b0, oe: 1'b0};
      ST_S8:                      o = '{as: 1'b1, ds: 1'b0, dben: 1'b1, rw: 1'b0, oe: 1'b1};
      ST_S9, ST_WWAIT, ST_S10:    o = '{as: 1'b1, ds: 1'b1, dben: 1'b1, rw: 1'b0, oe: 1'b1};
      ST_S11:                     o = '{as: 1'b0, ds: 1'b0, dben: 1'b0, rw: 1'b0, oe: 1'b1};
      default:                    o = '{as: 1'b0, ds: 1'b0, dben: 1'b0, rw: 1'b1, oe: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int IDLE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rd_only,
  input  logic       ack_seen,
  output bus_state_e state,
  output bus_state_e state_nxt
);

  localparam int GW = (IDLE_CLKS > 1) ? $clog2(IDLE_CLKS) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(IDLE_CLKS - 1);

  logic [GW-1:0] gap_cnt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (start) state_nxt = ST_S0;
      ST_S0:    state_nxt = ST_S1;
      ST_S1:    state_nxt = ST_S2;
      ST_S2:    state_nxt = ack_seen ? ST_S3 : ST_RWAIT;
      ST_RWAIT: if (ack_seen) state_nxt = ST_S3;
      ST_S3:    state_nxt = ST_S4;
      ST_S4:    state_nxt = ST_S5;
      ST_S5:    state_nxt = rd_only ? ST_IDLE : ST_GAP;
      ST_GAP:   if (gap_cnt == GAP_LAST) state_nxt = ST_S6;
      ST_S6:    state_nxt = ST_S7;
      ST_S7:    state_nxt = ST_S8;
      ST_S8:    state_nxt = ST_S9;
      ST_S9:    state_nxt = ack_seen ? ST_S10 : ST_WWAIT;
      ST_WWAIT: if (ack_seen) state_nxt = ST_S10;
      ST_S10:   state_nxt = ST_S11;
      ST_S11:   state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (state == ST_GAP) gap_cnt <= gap_cnt + 1'b1;
      else                 gap_cnt <= '0;
    end
  end

endmodule

// File: rtl/rmw_lanes.sv
module rmw_lanes #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = $clog2(DATA_W / 8)
) (
  input  logic [OFFS_W-1:0] offs,
  input  logic [OFFS_W-1:0] siz,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] bus_out
);

  localparam int LANES = DATA_W / 8;
  localparam logic [OFFS_W:0] LANES_V = (OFFS_W + 1)'(LANES);

  logic [OFFS_W:0]   nbytes;
  logic [OFFS_W:0]   span;
  logic [OFFS_W:0]   low_lane;
  logic [DATA_W-1:0] rd_shift;
  logic [DATA_W-1:0] wr_mask;

  always_comb begin
    nbytes   = (siz == '0) ? LANES_V : {1'b0, siz};
    span     = {1'b0, offs} + nbytes;
    low_lane = (span >= LANES_V) ? '0 : LANES_V - span;
    rd_shift = bus_in >> {low_lane, 3'b000};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    localparam logic [OFFS_W:0] IDX = (OFFS_W + 1)'(i);
    assign rd_val[8*i +: 8]  = (IDX < nbytes) ? rd_shift[8*i +: 8] : 8'h00;
    assign wr_mask[8*i +: 8] = (IDX < nbytes) ? wr_val[8*i +: 8]   : 8'h00;
  end

  assign bus_out = wr_mask << {low_lane, 3'b000};

endmodule

// File: rtl/rmw_bus_master.sv
module rmw_bus_master
  import rmw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int FC_W      = 3,
  parameter int ACK_W     = 2,
  parameter int IDLE_CLKS = 2,
  parameter int SIZE_W    = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [FC_W-1:0]   fc_in,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_only,
  input  logic [ACK_W-1:0]  ack,
  input  logic              cinh,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [FC_W-1:0]   bus_fc,
  output logic [SIZE_W-1:0] bus_siz,
  output logic              bus_rw,
  output logic              bus_as,
  output logic              bus_ds,
  output logic              bus_dben,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_uncached,
  output logic              done
);

  bus_state_e        st, st_nxt;
  strobe_t           strb;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0]   fc_q;
  logic [SIZE_W-1:0] siz_q;
  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] lane_rd;
  logic [DATA_W-1:0] lane_wr;
  logic              ro_q;
  logic              cinh_q;
  logic              unc_q;
  logic              done_q;
  logic              ack_seen;
  logic              accept;

  assign ack_seen = |ack;
  assign accept   = start && (st == ST_IDLE);

  rmw_seq #(.IDLE_CLKS(IDLE_CLKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_only  (ro_q),
    .ack_seen (ack_seen),
    .state    (st),
    .state_nxt(st_nxt)
  );

  rmw_lanes #(.DATA_W(DATA_W), .OFFS_W(SIZE_W)) u_lanes (
    .offs   (addr_q[SIZE_W-1:0]),
    .siz    (siz_q),
    .bus_in (bus_d_in),
    .wr_val (wr_q),
    .rd_val (lane_rd),
    .bus_out(lane_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      fc_q   <= '0;
      siz_q  <= '0;
      wr_q   <= '0;
      ro_q   <= 1'b1;
      strb   <= strobe_of(ST_IDLE);
      cinh_q <= 1'b0;
      unc_q  <= 1'b0;
      rd_q   <= '0;
      dout_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= addr_in;
        fc_q   <= fc_in;
        siz_q  <= size_in;
        wr_q   <= wr_data;
        ro_q   <= rd_only;
      end
      strb <= strobe_of(st_nxt);
      if (st == ST_S3) cinh_q <= cinh;
      if (st == ST_S4) begin
        rd_q  <= lane_rd;
        unc_q <= cinh_q;
      end
      if (st == ST_S7) dout_q <= lane_wr;
      done_q <= (st == ST_S5 && ro_q) || (st == ST_S11);
    end
  end

  assign bus_addr    = addr_q;
  assign bus_fc      = fc_q;
  assign bus_siz     = siz_q;
  assign bus_rw      = strb.rw;
  assign bus_as      = strb.as;
  assign bus_ds      = strb.ds;
  assign bus_dben    = strb.dben;
  assign bus_d_oe    = strb.oe;
  assign bus_d_out   = dout_q;
  assign rd_data     = rd_q;
  assign rd_uncached = unc_q;
  assign done        = done_q;

endmodule

// File: rtl/rmw_bus_master_chk.sv
module rmw_bus_master_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_as,
  input logic              bus_ds,
  input logic              bus_dben,
  input logic              bus_rw,
  input logic              bus_d_oe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              done
);

  // R11: outputs enabled only at write level
  assert_oe_write_level_R11: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> !bus_rw);

  // R2: data strobe only within an address strobe
  assert_ds_inside_as_R2: assert property (@(posedge clk) disable iff (rst)
    bus_ds |-> bus_as);

  // R2: buffers enabled only inside an address strobe
  assert_dben_inside_as_R2: assert property (@(posedge clk) disable iff (rst)
    bus_dben |-> bus_as);

  // R10: done lasts a single cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: address stays put while a strobe is held
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_as && $past(bus_as)) |-> $stable(bus_addr));

  // R6: drivers switch on only after R/W already went low
  assert_oe_after_rw_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_d_oe) |-> !$past(bus_rw));

endmodule

bind rmw_bus_master rmw_bus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_as  (bus_as),
  .bus_ds  (bus_ds),
  .bus_dben(bus_dben),
  .bus_rw  (bus_rw),
  .bus_d_oe(bus_d_oe),
  .bus_addr(bus_addr),
  .done    (done)
);

// File: tb/rmw_bus_master_tb.sv
module rmw_bus_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_CLKS  = 2;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] rd;
    logic        unc;
    int          rwait;
    int          wwait;
    logic        has_wr;
    logic [31:0] placed;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [31:0] addr_in = 0;
  logic [2:0]  fc_in = 0;
  logic [1:0]  size_in = 0;
  logic [31:0] wr_data = 0;
  logic        rd_only = 1;
  logic [1:0]  ack = 0;
  logic        cinh = 0;
  logic [31:0] bus_d_in = 0;
  logic [31:0] bus_addr, bus_d_out, rd_data;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic        bus_rw, bus_as, bus_ds, bus_dben, bus_d_oe, rd_uncached, done;

  int errs = 0;
  int checks = 0;
  exp_t q[$];

  // slave model
  int       slv_k = 1;
  logic [1:0] slv_sel = 2'b01;
  int       slv_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_bus_master #(.IDLE_CLKS(IDLE_CLKS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr_in), .fc_in(fc_in),
    .size_in(size_in), .wr_data(wr_data), .rd_only(rd_only), .ack(ack),
    .cinh(cinh), .bus_d_in(bus_d_in), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_siz(bus_siz), .bus_rw(bus_rw), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_dben(bus_dben), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .rd_data(rd_data), .rd_uncached(rd_uncached), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst || !bus_ds) begin
      slv_cnt = 0;
      ack = 2'b00;
    end else begin
      slv_cnt = slv_cnt + 1;
      ack = (slv_cnt >= slv_k) ? slv_sel : 2'b00;
    end
  end

  // monitor
  int cyc = 0, as_start = 0, as_fall = 0, rw_fall = 0, rd_run = 0, wr_run = 0;
  logic prev_as = 0, prev_rw = 1, prev_oe = 0, prev_done = 0, saw_wr = 0;
  exp_t e;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cyc > 20000) begin
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
      if (q.size() > 0 && bus_as && bus_addr !== q[0].addr)
        chk(0, "R8 address held", bus_addr, q[0].addr);
      if (bus_d_oe && bus_rw) chk(0, "R11 oe at read level", 1, 0);
      if (bus_as && !prev_as) as_start = cyc;
      if (!bus_as && prev_as) begin
        if (bus_rw) begin rd_run = cyc - as_start; as_fall = cyc; end
        else wr_run = cyc - as_start;
      end
      if (!bus_rw && prev_rw) begin
        saw_wr = 1;
        rw_fall = cyc;
        chk(cyc - as_fall == IDLE_CLKS + 1, "R6 rw fall delay", cyc - as_fall, IDLE_CLKS + 1);
      end
      if (bus_d_oe && !prev_oe && q.size() > 0) begin
        chk(cyc - rw_fall == 2, "R6 oe after rw", cyc - rw_fall, 2);
        chk(bus_d_out === q[0].placed, "R7 write lanes", bus_d_out, q[0].placed);
      end
      if (done && prev_done) chk(0, "R10 done width", 2, 1);
      if (done && !prev_done && q.size() > 0) begin
        e = q.pop_front();
        chk(rd_data === e.rd, "R4 read data", rd_data, e.rd);
        chk(rd_uncached === e.unc, "R12 uncached flag", rd_uncached, e.unc);
        chk(rd_run == 4 + e.rwait, "R3 read strobe width", rd_run, 4 + e.rwait);
        chk(saw_wr == e.has_wr, "R5 write portion present", saw_wr, e.has_wr);
        if (e.has_wr)
          chk(wr_run == 4 + e.wwait, "R3 write strobe width", wr_run, 4 + e.wwait);
        saw_wr = 0;
      end
      prev_as = bus_as; prev_rw = bus_rw; prev_oe = bus_d_oe; prev_done = done;
    end
  end

  // driver: pushes the expected result then issues the request
  task automatic run_op(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd,
                        input logic ro, input logic [31:0] word, input logic ci,
                        input int k, input logic [1:0] sel, input bit poke);
    exp_t x;
    int n, lo;
    logic [63:0] m;
    n  = (sz == 0) ? 4 : int'(sz);
    lo = 8 * (4 - int'(a[1:0]) - n);
    m  = (64'd1 << (8 * n)) - 1;
    x.addr   = a;
    x.rd     = 32'((64'(word) >> lo) & m);
    x.unc    = ci;
    x.rwait  = (k > 2) ? k - 2 : 0;
    x.wwait  = (k > 1) ? k - 1 : 0;
    x.has_wr = !ro;
    x.placed = 32'((64'(wd) & m) << lo);
    q.push_back(x);
    slv_k = k; slv_sel = sel; bus_d_in = word; cinh = ci;
    addr_in = a; size_in = sz; wr_data = wd; rd_only = ro; fc_in = 3'd5;
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R9: a second request while busy must be ignored
      repeat (3) @(negedge clk);
      addr_in = 32'hDEAD_0000; rd_only = 1; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(bus_as == 0 && bus_ds == 0 && bus_dben == 0 && bus_d_oe == 0 && bus_rw == 1,
        "R1 reset strobes", {bus_as, bus_ds, bus_dben, bus_d_oe, bus_rw}, 5'b00001);
    rst = 0;
    @(negedge clk);
    chk(done == 0 && bus_as == 0 && bus_rw == 1, "R1 after reset", {done, bus_as, bus_rw}, 3'b001);

    run_op(32'h0000_0100, 2'b00, 32'h0, 1, 32'hA1B2_C3D4, 0, 1, 2'b01, 0); // R2 R5 long read, no wait
    run_op(32'h0000_0201, 2'b01, 32'h0, 1, 32'hA1B2_C3D4, 1, 4, 2'b10, 0); // R3 two waits, other ack bit
    run_op(32'h0000_0302, 2'b10, 32'h1234, 0, 32'hA1B2_C3D4, 0, 2, 2'b01, 0); // R6 R7 word RMW
    run_op(32'h0000_0400, 2'b11, 32'hFFAA_BBCC, 0, 32'h1122_3344, 1, 5, 2'b11, 0); // R4 three bytes, long waits
    run_op(32'h0000_0500, 2'b00, 32'hCAFE_F00D, 0, 32'h5566_7788, 0, 1, 2'b11, 1); // R9 poke while busy
    run_op(32'h0000_0603, 2'b01, 32'h0, 1, 32'h0102_03EE, 1, 3, 2'b01, 0); // R4 top offset byte

    // R10: result held after done
    repeat (5) @(negedge clk);
    chk(rd_data === 32'hEE, "R10 read data held", rd_data, 32'hEE);
    chk(rd_uncached === 1'b1, "R10 uncached held", rd_uncached, 1);
    chk(bus_as == 0 && done == 0, "R5 idle after op", {bus_as, done}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule